// File: doc/BRIEF.md
# Pulse-Swallowing Phase Stepper

This block divides a fast input clock by a fixed total ratio to produce a reference-rate tick, built as a dual-modulus prescaler (divide by 10 or by 11) that is followed by a program counter of ten counts. By default the total ratio is 100. On request, one output period is stretched by exactly one input cycle. This deletes one input pulse and retards the output phase by one hundredth of a cycle, which is 3.6 degrees at the default ratio.

Two such dividers feed two synthesizer channels. Stepping one of them walks the relative phase of the channels in known increments, which is how a phase shifter is calibrated. The request input is asynchronous. In single-step mode each rising edge of the request produces one step. In continuous mode a step is applied in every period while the request is held, so that channel moves off frequency relative to the other. A counter reports the number of applied steps modulo the total ratio, so it reads directly in phase steps.

Top module: `pss_phase_stepper`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `out_tick` is 0 and `step_count` is 0.
- R2: With no step applied, `out_tick` pulses once every PRE_DIV*PROG_CNT input cycles (100 by default).
- R3: `out_tick` is high for exactly one input cycle at each period boundary.
- R4: With `mode` = 0 (single step), a rising edge on `swallow_req` that reaches the block more than SYNC_STAGES+2 cycles before a period boundary makes the period that starts at that boundary last PRE_DIV*PROG_CNT+1 cycles (101). Every other period stays at 100.
- R5: In single-step mode, holding `swallow_req` high across several boundaries produces only one stretched period.
- R6: In single-step mode, several rising edges within one period produce only one stretched period.
- R7: With `mode` = 1 (continuous), each period that starts at a boundary where the synchronized request is high lasts 101 cycles. Periods that start while the request is low last 100 cycles.
- R8: `step_count` increases by one, modulo PRE_DIV*PROG_CNT (99 wraps to 0), in the same cycle as the `out_tick` that opens a stretched period. At all other times it holds its value.
- R9: No output period is shorter than 100 cycles or longer than 101 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0: one step per request edge; 1: step every period while request held |
| swallow_req | input | 1 | Asynchronous step request |
| out_tick | output | 1 | One-cycle pulse at each output period boundary |
| step_count | output | $clog2(PRE_DIV*PROG_CNT) | Applied steps modulo the total ratio |

## Verification
On every cycle, the assertions check that the tick lasts a single cycle, that the spacing between ticks is only ever 100 or 101 cycles, and that the step counter changes only at a tick and only by a wrapping increment. The properties cannot tell whether a stretch was actually requested. Only the bench scenarios show that: they tie each 101-cycle period to the request that caused it, collapse held levels and repeated edges to a single step in single-step mode, step on every held period in continuous mode, and carry the counter through its wrap from 99 to 0.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic {
        STEP_SINGLE = 1'b0,
        STEP_HOLD   = 1'b1
    } step_mode_e;

    // Smallest counter width able to hold values 0..n-1 (at least 1 bit).
    function automatic int cnt_width(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

    // Next value of a counter that wraps to zero after limit-1.
    function automatic int wrap_inc(input int value, input int limit);
        return (value >= limit - 1) ? 0 : value + 1;
    endfunction

endpackage

// File: rtl/pss_req_sync.sv
module pss_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/pss_prescaler.sv
module pss_prescaler #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic extend,
    output logic tc
);
    localparam int CW = pss_pkg::cnt_width(DIV + 1);
    localparam logic [CW-1:0] LAST_N = CW'(DIV - 1);
    localparam logic [CW-1:0] LAST_X = CW'(DIV);

    logic [CW-1:0] cnt;

    // extend only changes on tc, so the modulus is fixed for a whole cycle
    assign tc = (cnt == (extend ? LAST_X : LAST_N));

    always_ff @(posedge clk) begin
        if (rst)     cnt <= '0;
        else if (tc) cnt <= '0;
        else         cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pss_prog_counter.sv
module pss_prog_counter #(
    parameter int COUNT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic first,
    output logic wrap
);
    localparam int PW = pss_pkg::cnt_width(COUNT);
    localparam logic [PW-1:0] LAST = PW'(COUNT - 1);

    logic [PW-1:0] cnt;

    assign first = (cnt == '0);
    assign wrap  = adv && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (wrap) cnt <= '0;
        else if (adv)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pss_swallow_ctrl.sv
module pss_swallow_ctrl
    import pss_pkg::*;
#(
    parameter int TOTAL = 100
) (
    input  logic                          clk,
    input  logic                          rst,
    input  step_mode_e                    mode,
    input  logic                          req_level,
    input  logic                          req_rise,
    input  logic                          boundary,
    output logic                          active,
    output logic                          tick,
    output logic [cnt_width(TOTAL)-1:0]   steps
);
    localparam int SW = cnt_width(TOTAL);
    localparam logic [SW-1:0] LAST = SW'(TOTAL - 1);

    logic pending;
    logic next_active;

    always_comb begin
        if (mode == STEP_HOLD) next_active = req_level;
        else                   next_active = pending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            active  <= 1'b0;
            tick    <= 1'b0;
            steps   <= '0;
        end else begin
            tick <= boundary;
            if (mode == STEP_HOLD) begin
                pending <= 1'b0;
            end else if (boundary) begin
                pending <= req_rise;
            end else if (req_rise) begin
                pending <= 1'b1;
            end
            if (boundary) begin
                active <= next_active;
                if (next_active) steps <= (steps == LAST) ? '0 : steps + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pss_phase_stepper.sv
module pss_phase_stepper
    import pss_pkg::*;
#(
    parameter int PRE_DIV     = 10,
    parameter int PROG_CNT    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   mode,
    input  logic                                   swallow_req,
    output logic                                   out_tick,
    output logic [cnt_width(PRE_DIV*PROG_CNT)-1:0] step_count
);
    localparam int TOTAL = PRE_DIV * PROG_CNT;

    logic req_level, req_rise;
    logic active, first_count, pre_tc, boundary;

    pss_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(swallow_req),
        .level(req_level), .rise(req_rise)
    );

    // The one stretched prescale cycle is the first of the period.
    pss_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst(rst), .extend(active && first_count), .tc(pre_tc)
    );

    pss_prog_counter #(.COUNT(PROG_CNT)) u_prog (
        .clk(clk), .rst(rst), .adv(pre_tc),
        .first(first_count), .wrap(boundary)
    );

    pss_swallow_ctrl #(.TOTAL(TOTAL)) u_ctrl (
        .clk(clk), .rst(rst), .mode(step_mode_e'(mode)),
        .req_level(req_level), .req_rise(req_rise), .boundary(boundary),
        .active(active), .tick(out_tick), .steps(step_count)
    );
endmodule

// File: rtl/pss_phase_stepper_chk.sv
module pss_phase_stepper_chk #(
    parameter int TOTAL = 100,
    parameter int SW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          out_tick,
    input logic [SW-1:0] step_count
);
    localparam int GW = $clog2(TOTAL + 3) + 1;
    localparam logic [GW-1:0] GAP_N   = GW'(TOTAL);
    localparam logic [GW-1:0] GAP_X   = GW'(TOTAL + 1);
    localparam logic [GW-1:0] GAP_SAT = GW'(TOTAL + 2);
    localparam logic [SW-1:0] LAST    = SW'(TOTAL - 1);

    logic [GW-1:0] since;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
            seen  <= 1'b0;
        end else if (out_tick) begin
            since <= GW'(1);
            seen  <= 1'b1;
        end else if (since != GAP_SAT) begin
            since <= since + 1'b1;
        end
    end

    assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
        out_tick |=> !out_tick);

    assert_gap_at_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (out_tick && seen) |-> (since == GAP_N || since == GAP_X));

    assert_gap_bound_R9: assert property (@(posedge clk) disable iff (rst)
        seen |-> (since <= GAP_X));

    assert_step_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !out_tick |-> $stable(step_count));

    assert_step_inc_R8: assert property (@(posedge clk) disable iff (rst)
        (out_tick && !$stable(step_count)) |->
            (step_count == (($past(step_count) == LAST) ? '0 : $past(step_count) + 1'b1)));
endmodule

bind pss_phase_stepper pss_phase_stepper_chk #(
    .TOTAL(PRE_DIV * PROG_CNT),
    .SW(pss_pkg::cnt_width(PRE_DIV * PROG_CNT))
) u_chk (
    .clk(clk), .rst(rst), .out_tick(out_tick), .step_count(step_count)
);

// File: tb/pss_phase_stepper_tb.sv
`timescale 1ns/1ps
module pss_phase_stepper_tb;
    localparam int TOTAL = 100;

    typedef struct {
        int    gap;
        int    step;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic       swallow_req = 1'b0;
    logic       out_tick;
    logic [6:0] step_count;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t expq[$];

    int   exp_step = 0;
    bit   last_dec = 0;
    bit   req_high = 0;

    always #2.5 clk = ~clk;

    pss_phase_stepper u_dut (
        .clk(clk), .rst(rst), .mode(mode), .swallow_req(swallow_req),
        .out_tick(out_tick), .step_count(step_count)
    );

    task automatic check(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: scoreboard side
    int  cyc = 0;
    int  last_tick_cyc = 0;
    bit  prev_tick = 0;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (out_tick) begin
                exp_t e;
                check("R3 tick preceded by low", int'(prev_tick), 0);
                if (expq.size() == 0) begin
                    check("R2 unexpected tick", 1, 0);
                end else begin
                    e = expq.pop_front();
                    if (e.gap != 0) check(e.tag, cyc - last_tick_cyc, e.gap);
                    check("R8 step_count", int'(step_count), e.step);
                end
                last_tick_cyc = cyc;
            end
            prev_tick = out_tick;
        end
    end

    task automatic wait_tick();
        do @(negedge clk); while (!out_tick);
    endtask

    // kind: 0 idle, 1 pulse, 2 hold high, 3 double pulse
    task automatic run_period(input int kind, input string tag);
        bit dec;
        exp_t e;
        case (kind)
            0: dec = 0;
            1, 3: dec = 1;
            default: dec = (mode == 1'b1) ? 1'b1 : !req_high;
        endcase
        exp_step = (exp_step + int'(dec)) % TOTAL;
        e.gap  = last_dec ? TOTAL + 1 : TOTAL;
        e.step = exp_step;
        e.tag  = tag;
        expq.push_back(e);
        last_dec = dec;
        repeat (20) @(negedge clk);
        case (kind)
            0: begin swallow_req = 0; req_high = 0; end
            1: begin
                swallow_req = 1; repeat (3) @(negedge clk); swallow_req = 0;
                req_high = 0;
            end
            3: begin
                swallow_req = 1; repeat (3) @(negedge clk); swallow_req = 0;
                repeat (10) @(negedge clk);
                swallow_req = 1; repeat (3) @(negedge clk); swallow_req = 0;
                repeat (10) @(negedge clk);
                swallow_req = 1; repeat (3) @(negedge clk); swallow_req = 0;
                req_high = 0;
            end
            default: begin swallow_req = 1; req_high = 1; end
        endcase
        wait_tick();
    endtask

    initial begin
        exp_t e0;
        repeat (4) @(negedge clk);
        check("R1 out_tick in reset", int'(out_tick), 0);
        check("R1 step_count in reset", int'(step_count), 0);
        e0.gap = 0; e0.step = 0; e0.tag = "R2";
        expq.push_back(e0);
        rst = 0;
        @(negedge clk);
        check("R1 out_tick after release", int'(out_tick), 0);
        check("R1 step_count after release", int'(step_count), 0);
        wait_tick();

        // R2: steady division
        repeat (3) run_period(0, "R2 idle period");
        // R4: single pulse
        run_period(1, "R4 single step");
        repeat (2) run_period(0, "R4 period after step");
        // R5: held level in single mode
        repeat (3) run_period(2, "R5 held request");
        repeat (2) run_period(0, "R5 after release");
        // R6: several edges in one period
        run_period(3, "R6 multiple edges");
        repeat (2) run_period(0, "R6 after edges");
        // R7: continuous mode
        mode = 1'b1;
        repeat (5) run_period(2, "R7 continuous held");
        repeat (2) run_period(0, "R7 continuous released");
        // R8: wrap of the step counter
        repeat (TOTAL) run_period(2, "R8 wrap run");
        repeat (2) run_period(0, "R8 after wrap");
        mode = 1'b0;
        run_period(1, "R4 single after continuous");
        run_period(0, "R4 final");
        repeat (5) @(negedge clk);
        check("R2 scoreboard drained", expq.size(), 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule